// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Transmitter

This block serialises bytes onto a single asynchronous line. Software writes a byte into a one-entry holding register. The block moves that byte into a shift register only when the shift register is free. A clear-to-send handshake can also gate the move. When the handshake is enabled, a high level on the clear-to-send pin holds back the next frame. A frame that has already started always runs to its end, and a held-back frame starts on the first bit boundary after the pin goes low again. When the handshake is disabled, the pin has no effect and frames leave back to back.

Bit timing comes from an external enable that pulses at sixteen times the bit rate. A free-running phase counter divides that enable into bit periods. Every frame starts on a bit boundary of this counter, so the start bit always lines up with the transmit bit clock. Each move from the holding register into the shift register produces a one-clock interrupt pulse. While transmission is held off, software can therefore refill the holding register, and that byte waits for permission to go out. Receive logic and a request-to-send output are not part of the block. Receive-side flow control is left to a general-purpose port.

Top module: `uart_cts_tx`

## Requirements
- R1: A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts 16 bit-clock enable pulses. The line rests high while no frame is in progress.
- R2: A frame's start bit begins at a bit boundary. The number of enable pulses seen since reset release is a multiple of 16 when the line first goes low.
- R3: With the handshake disabled (hs_en_i = 0), the clear-to-send pin is ignored. A byte that is waiting starts exactly 160 enable pulses after the previous start, with no idle gap.
- R4: With the handshake enabled (hs_en_i = 1), a frame under way when cts_ni goes high finishes intact. No further frame starts while the pin stays high, and during that time the line stays high and busy_o stays low.
- R5: After cts_ni returns low, a waiting frame starts on the first bit boundary that follows the two-flop synchroniser. That is between 3 and 18 enable pulses after the low level is first presented to the clock, when the enable is high every cycle.
- R6: The holding register moves into the shift register only when the shift register is free, the holding register is full, and either the handshake is disabled or the synchronised pin is low. Every such move raises tbe_irq_o for exactly one clock, and no pulse appears otherwise.
- R7: While transmission is held off, the holding register accepts a byte written after the interrupt, without flagging an overrun. That byte is sent once the pin allows it.
- R8: A write while the holding register is full is dropped and never sent. It sets ovr_o, which stays high until reset.
- R9: busy_o is high from the start bit through the stop bit of every frame and low when no frame is in progress.
- R10: After reset, txd_o is high and busy_o, tbe_irq_o and ovr_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | Enable pulse at sixteen times the bit rate |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Byte to transmit |
| hs_en_i | input | 1 | 1 enables clear-to-send gating |
| cts_ni | input | 1 | Clear-to-send pin, low means send allowed |
| txd_o | output | 1 | Serial data line, idles high |
| tbe_irq_o | output | 1 | One-clock pulse when the holding register empties into the shifter |
| busy_o | output | 1 | High while a frame is on the line |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that hs_en_i changes only while no frame is queued. They also assume that the pin level they check against is the synchronised copy, not the raw input. The bench meets both assumptions: it flips the mode only when the line is idle and the holding register is empty. It also changes cts_ni just after a rising edge, so the synchroniser's first flop sees a settled level. The sweep sends every byte value with the handshake off and the enable high every cycle. It repeats a short burst with the enable high only one cycle in three, then runs the hold, release and overrun cases with the handshake on.

// File: rtl/uctx_pkg.sv
package uctx_pkg;
  // start bit plus stop bit around the data field
  localparam int unsigned FRAME_OVERHEAD = 2;

  function automatic int unsigned frame_len(input int unsigned data_w);
    return data_w + FRAME_OVERHEAD;
  endfunction
endpackage

// File: rtl/uctx_sync.sv
module uctx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/uctx_holdbuf.sv
module uctx_holdbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              ovr
);
  logic              full_q, full_d;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              accept;

  always_comb begin
    accept = wr && !full_q;
    full_d = full_q;
    data_d = data_q;
    ovr_d  = ovr_q || (wr && full_q);
    if (take)   full_d = 1'b0;
    if (accept) begin
      full_d = 1'b1;
      data_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      ovr_q  <= ovr_d;
      if (accept) data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;
  assign ovr  = ovr_q;
endmodule

// File: rtl/uctx_shifter.sv
module uctx_shifter
  import uctx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  output logic              bit_edge,
  output logic              free,
  output logic              busy,
  output logic              txd
);
  localparam int unsigned PH_W       = $clog2(OVS);
  localparam int unsigned FRAME_BITS = frame_len(DATA_W);
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);

  logic [PH_W-1:0]       ph_q, ph_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  busy_q, busy_d;
  logic                  last_bit;

  always_comb begin
    bit_edge = tick && (ph_q == PH_W'(OVS-1));
    last_bit = (cnt_q == CNT_W'(FRAME_BITS-1));
    free     = !busy_q || last_bit;

    ph_d = ph_q;
    if (tick) ph_d = bit_edge ? '0 : ph_q + 1'b1;

    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = {1'b1, ld_data, 1'b0};
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (bit_edge && busy_q) begin
      if (last_bit) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      cnt_q  <= '0;
      sh_q   <= '1;
      busy_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign txd  = sh_q[0] || !busy_q;
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hs_en_i,
  input  logic              cts_ni,
  output logic              txd_o,
  output logic              tbe_irq_o,
  output logic              busy_o,
  output logic              ovr_o
);
  logic              cts_hold;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              bit_edge;
  logic              sh_free;
  logic              load;
  logic              irq_q, irq_d;

  uctx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk_i), .rst_n(rst_ni), .d(cts_ni), .q(cts_hold)
  );

  uctx_holdbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk_i), .rst_n(rst_ni), .wr(wr_i), .wdata(wdata_i),
    .take(load), .full(buf_full), .data(buf_data), .ovr(ovr_o)
  );

  uctx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk(clk_i), .rst_n(rst_ni), .tick(tick16_i), .load(load),
    .ld_data(buf_data), .bit_edge(bit_edge), .free(sh_free),
    .busy(busy_o), .txd(txd_o)
  );

  // move only at a bit boundary, into a free shifter, when allowed
  always_comb begin
    load  = bit_edge && sh_free && buf_full && (!hs_en_i || !cts_hold);
    irq_d = load;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign tbe_irq_o = irq_q;
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic busy,
  input logic irq,
  input logic ovr,
  input logic hs_en,
  input logic cts_hold
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_with_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (busy && !txd));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && cts_hold && !busy) |=> !busy);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
  .clk(clk_i), .rst_n(rst_ni), .txd(txd_o), .busy(busy_o),
  .irq(tbe_irq_o), .ovr(ovr_o), .hs_en(hs_en_i), .cts_hold(cts_hold)
);

// File: tb/sim_uart_cts_tx.sv
module sim_uart_cts_tx;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       hs_en = 1'b0;
  logic       cts_n = 1'b1;
  logic       txd, irq, busy, ovr;

  always #(CLK_P/2) clk = ~clk;

  uart_cts_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick16), .wr_i(wr),
    .wdata_i(wdata), .hs_en_i(hs_en), .cts_ni(cts_n), .txd_o(txd),
    .tbe_irq_o(irq), .busy_o(busy), .ovr_o(ovr)
  );

  int nchk = 0, nbad = 0;
  bit done = 0;
  bit tick_on = 0, gap = 0;
  int tk = 0, nstart = 0, nrx = 0, nirq = 0, rel_tk = 0;
  int st [0:299];
  logic [7:0] expq [0:299];
  int wp = 0, rp = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // line monitor and enable generator, one step per falling edge
  initial begin
    bit inf = 0, inc, irq_prev = 0, cts_prev = 1;
    int s = 0, bi = 0, cyc = 0;
    logic [7:0] rb = 8'h00;
    forever begin
      @(negedge clk);
      inc = 0;
      if (tick16) begin tk++; inc = 1; end
      if (irq) begin
        nirq++;
        if (irq_prev) chk(0, "R6", "irq wider than one clock", 2, 1);
      end
      irq_prev = irq;
      if (cts_prev && !cts_n) rel_tk = tk;
      cts_prev = cts_n;
      if (!inf) begin
        if (!txd) begin
          inf = 1; s = tk; bi = 0;
          st[nstart] = tk; nstart++;
          chk(tk % 16 == 0, "R2", "start phase", tk % 16, 0);
        end
      end else if (inc && tk == s + 16*bi + 8) begin
        chk(busy, "R9", "busy mid-bit", int'(busy), 1);
        if (bi == 0) chk(!txd, "R1", "start bit level", int'(txd), 0);
        else if (bi <= 8) rb[bi-1] = txd;
        else begin
          chk(txd, "R1", "stop bit level", int'(txd), 1);
          chk(rb == expq[rp], "R1", "received byte", int'(rb), int'(expq[rp]));
          rp++; nrx++; inf = 0;
        end
        bi++;
      end
      tick16 = tick_on ? (gap ? (cyc % 3 == 0) : 1'b1) : 1'b0;
      cyc++;
    end
  end

  task automatic put(input logic [7:0] b, input bit push);
    @(negedge clk);
    wr = 1'b1; wdata = b;
    if (push) begin expq[wp] = b; wp++; end
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_irq();
    do @(negedge clk); while (!irq);
  endtask

  task automatic wait_rx(input int n);
    while (nrx < n) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cts(input logic v);
    @(posedge clk);
    #1 cts_n = v;
  endtask

  initial begin
    int base, k, ns, i0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(txd == 1'b1, "R10", "txd after reset", int'(txd), 1);
    chk(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
    chk(irq == 1'b0, "R10", "irq after reset", int'(irq), 0);
    chk(ovr == 1'b0, "R10", "ovr after reset", int'(ovr), 0);
    tick_on = 1;

    // R3 all byte values back to back, pin held high but ignored
    hs_en = 1'b0; cts_n = 1'b1;
    put(8'h00, 1);
    for (int b = 1; b < 256; b++) begin
      wait_irq();
      put(b[7:0], 1);
    end
    wait_rx(256);
    for (int i = 1; i < 256; i++)
      chk(st[i] - st[i-1] == 160, "R3", "start spacing", st[i] - st[i-1], 160);
    chk(busy == 1'b0, "R9", "busy after burst", int'(busy), 0);
    chk(nirq == 256, "R6", "irq count after sweep", nirq, 256);

    // R1 R3 sparse enable: one pulse every third cycle
    gap = 1; set_cts(1'b0);
    base = nstart;
    put(8'hA5, 1);
    for (int i = 1; i < 5; i++) begin
      wait_irq();
      put(8'hA5 ^ 8'(i*37), 1);
    end
    wait_rx(261);
    for (int i = base + 1; i < base + 5; i++)
      chk(st[i] - st[i-1] == 160, "R3", "sparse spacing", st[i] - st[i-1], 160);
    gap = 0;

    // R4 R5 R7 hold-off in the middle of a frame
    hs_en = 1'b1;
    repeat (5) @(negedge clk);
    k = nrx;
    put(8'h3C, 1);
    wait_irq();
    put(8'hC3, 1);
    @(negedge clk);
    chk(ovr == 1'b0, "R7", "no overrun on refill", int'(ovr), 0);
    repeat (40) @(negedge clk);
    set_cts(1'b1);
    wait_rx(k + 1);
    ns = nstart;
    repeat (300) @(negedge clk);
    chk(nstart == ns, "R4", "frames started while held", nstart, ns);
    chk(busy == 1'b0, "R4", "busy while held", int'(busy), 0);
    chk(txd == 1'b1, "R4", "line while held", int'(txd), 1);
    set_cts(1'b0);
    while (nstart == ns) @(negedge clk);
    chk(st[ns] - rel_tk >= 3 && st[ns] - rel_tk <= 18, "R5",
        "release to start", st[ns] - rel_tk, 3);
    wait_rx(k + 2);
    chk(ovr == 1'b0, "R7", "held byte sent without overrun", int'(ovr), 0);

    // R6 R8 overrun while held with an idle shifter
    set_cts(1'b1);
    repeat (10) @(negedge clk);
    i0 = nirq;
    k = nrx;
    put(8'h5A, 1);
    repeat (60) @(negedge clk);
    chk(busy == 1'b0, "R6", "no move while pin high", int'(busy), 0);
    chk(nirq == i0, "R6", "no irq while pin high", nirq, i0);
    chk(ovr == 1'b0, "R8", "ovr before second write", int'(ovr), 0);
    put(8'h99, 0);
    @(negedge clk);
    chk(ovr == 1'b1, "R8", "ovr after write to full", int'(ovr), 1);
    set_cts(1'b0);
    wait_rx(k + 1);
    ns = nstart;
    repeat (300) @(negedge clk);
    chk(nstart == ns, "R8", "dropped byte not sent", nstart, ns);
    chk(ovr == 1'b1, "R8", "ovr stays set", int'(ovr), 1);
    chk(nirq == nstart, "R6", "one irq per frame", nirq, nstart);

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule